// File: doc/BRIEF.md
# Indirect Register Access Command Port

This block is the host-facing control port of a larger switching device. An 8-bit host sees only four byte-wide registers, picked by a 2-bit register select: a command/status byte, an internal address byte and a 16-bit data word split into a low byte and a high byte. The host reaches the device's bank of 16-bit internal registers indirectly. It loads the address and the data bytes, then sets a read bit or a write bit in the command byte.

A few internal addresses (below `LOCAL_REGS`) are held inside the port and complete in a single host cycle. All other addresses belong to the core, which runs on its own clock. For these, the port toggles a request line toward the core, raises a busy flag and waits for a toggled acknowledge before it drops busy and clears the command bit. On the core side a small bus master issues one strobe per request and captures the read data. A sticky abort bit lets the host finish a hung command when the core clock has stopped. A self-clearing reset bit returns the host registers to zero.

Top module: `host_cmd_port`

## Requirements
- R1: Register select 0 is command/status, 1 is internal address, 2 is data bits 7:0 and 3 is data bits 15:8. After reset, all four read 0.
- R2: In the command/status byte, bits 6:4 always read 0, and writing them has no effect.
- R3: Writing command bit 2 (write) at a core address stores the 16-bit data at that internal address. Status reads 0x05 (busy and write) until the core acknowledges, then 0x00.
- R4: Writing command bit 1 (read) at a core address holds busy (status 0x03) until the core returns data. When busy reads 0, both data bytes hold the 16-bit value read.
- R5: A read or write to an address below `LOCAL_REGS` completes in the host write cycle and never raises busy. The data stays in the port.
- R6: If bits 1 and 2 are both written as 1, only the read is carried out and the write is dropped without an error.
- R7: While busy is 1, writes to the address and data registers are ignored.
- R8: Writing command bit 3 (abort) while busy clears busy and the read and write bits without any core clock. Status reads 0x08. The bit stays set until the host writes 0, and new commands are ignored while it is set or being set.
- R9: Writing command bit 7 (reset) clears the address, the data, the local registers, busy and abort. Bit 7 reads back as 0.
- R10: Each core-bound command produces exactly one single-cycle strobe on the core bus, carrying the internal address, the data and the write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst | input | 1 | Host-domain synchronous reset, active high |
| h_sel | input | 2 | Host register select |
| h_wr_en | input | 1 | Host write strobe for the selected register |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Contents of the selected register |
| cclk | input | 1 | Core clock |
| crst | input | 1 | Core-domain synchronous reset, active high |
| bus_valid | output | 1 | Single-cycle core bus strobe |
| bus_write | output | 1 | Core bus direction, 1 for write |
| bus_addr | output | 8 | Core bus internal address |
| bus_wdata | output | 16 | Core bus write data |
| bus_rdata | input | 16 | Core bus read data, sampled on the strobe cycle |

## Verification
The bench builds the port with `LOCAL_REGS` = 4 and `SYNC_STAGES` = 3. Addresses 2 and 3 therefore take the one-cycle local path, while 0x20 and above go through the clock crossing. The three-stage synchronizers stretch each busy window to several host cycles, so host writes issued in the middle of a command land inside it. This lets the bench check the busy lock and the read-over-write priority. The core clock runs at a period unrelated to the host clock and can be gated off, so an abort can be tried against a core that truly does not respond. Afterwards the bench checks that a late core response does no harm.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

    localparam int HB = 8;
    localparam int DW = 16;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'b00,
        SEL_ADDR = 2'b01,
        SEL_DLO  = 2'b10,
        SEL_DHI  = 2'b11
    } hsel_e;

    localparam int BIT_BUSY = 0;
    localparam int BIT_RD   = 1;
    localparam int BIT_WR   = 2;
    localparam int BIT_TERM = 3;
    localparam int BIT_RST  = 7;

    typedef struct packed {
        logic term;
        logic wr;
        logic rd;
        logic busy;
    } ctl_t;

    typedef struct packed {
        logic          write;
        logic [HB-1:0] addr;
        logic [DW-1:0] data;
    } xfer_t;

    function automatic logic is_local(input logic [HB-1:0] a, input int unsigned n);
        return ({24'd0, a} < n);
    endfunction

    function automatic logic [HB-1:0] pack_status(input ctl_t c);
        return {4'b0000, c.term, c.wr, c.rd, c.busy};
    endfunction

endpackage

// File: rtl/hcp_sync.sv
module hcp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/hcp_host_regs.sv
module hcp_host_regs
    import hcp_pkg::*;
#(
    parameter int LOCAL_REGS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    sel,
    input  logic          wr_en,
    input  logic [HB-1:0] wdata,
    output logic [HB-1:0] rdata,
    input  logic          ack_s,
    input  logic [DW-1:0] core_rdata,
    output logic          req_tgl,
    output xfer_t         xfer,
    output ctl_t          ctl,
    output logic [HB-1:0] addr
);
    localparam int LW = (LOCAL_REGS > 1) ? $clog2(LOCAL_REGS) : 1;

    ctl_t          ctl_q;
    logic [HB-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          req_q;
    logic [DW-1:0] bank [LOCAL_REGS];

    logic cmd_wr, soft_rst, done, term_next, can_start;
    logic start_rd, start_wr, local_hit;

    always_comb begin
        cmd_wr    = wr_en && (hsel_e'(sel) == SEL_CMD);
        soft_rst  = cmd_wr && wdata[BIT_RST];
        done      = ctl_q.busy && (ack_s == req_q);
        term_next = cmd_wr ? wdata[BIT_TERM] : ctl_q.term;
        can_start = !ctl_q.busy && !term_next;
        start_rd  = cmd_wr && wdata[BIT_RD] && can_start;
        start_wr  = cmd_wr && wdata[BIT_WR] && !wdata[BIT_RD] && can_start;
        local_hit = is_local(addr_q, LOCAL_REGS);
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            ctl_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            for (int i = 0; i < LOCAL_REGS; i++) bank[i] <= '0;
            if (rst) req_q <= 1'b0;
        end else begin
            ctl_q.term <= term_next;
            if (term_next && ctl_q.busy) begin
                ctl_q.busy <= 1'b0;
                ctl_q.rd   <= 1'b0;
                ctl_q.wr   <= 1'b0;
            end else if (done) begin
                ctl_q.busy <= 1'b0;
                ctl_q.rd   <= 1'b0;
                ctl_q.wr   <= 1'b0;
                if (ctl_q.rd) data_q <= core_rdata;
            end else if (start_rd || start_wr) begin
                if (local_hit) begin
                    if (start_rd) data_q <= bank[addr_q[LW-1:0]];
                    else          bank[addr_q[LW-1:0]] <= data_q;
                end else begin
                    ctl_q.busy <= 1'b1;
                    ctl_q.rd   <= start_rd;
                    ctl_q.wr   <= start_wr;
                    req_q      <= ~req_q;
                end
            end
            if (wr_en && !ctl_q.busy) begin
                case (hsel_e'(sel))
                    SEL_ADDR: addr_q       <= wdata;
                    SEL_DLO:  data_q[7:0]  <= wdata;
                    SEL_DHI:  data_q[15:8] <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (hsel_e'(sel))
            SEL_CMD:  rdata = pack_status(ctl_q);
            SEL_ADDR: rdata = addr_q;
            SEL_DLO:  rdata = data_q[7:0];
            default:  rdata = data_q[15:8];
        endcase
    end

    assign req_tgl    = req_q;
    assign xfer.write = ctl_q.wr;
    assign xfer.addr  = addr_q;
    assign xfer.data  = data_q;
    assign ctl        = ctl_q;
    assign addr       = addr_q;
endmodule

// File: rtl/hcp_core_master.sv
module hcp_core_master
    import hcp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_s,
    input  xfer_t         xfer,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [HB-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    output logic          ack_tgl,
    output logic [DW-1:0] rdata_q
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            rdata_q <= '0;
        end else if (bus_valid) begin
            seen_q <= req_s;
            if (!xfer.write) rdata_q <= bus_rdata;
        end
    end

    assign bus_valid = req_s ^ seen_q;
    assign bus_write = xfer.write;
    assign bus_addr  = xfer.addr;
    assign bus_wdata = xfer.data;
    assign ack_tgl   = seen_q;
endmodule

// File: rtl/host_cmd_port.sv
module host_cmd_port
    import hcp_pkg::*;
#(
    parameter int LOCAL_REGS  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        hclk,
    input  logic        hrst,
    input  logic [1:0]  h_sel,
    input  logic        h_wr_en,
    input  logic [7:0]  h_wdata,
    output logic [7:0]  h_rdata,
    input  logic        cclk,
    input  logic        crst,
    output logic        bus_valid,
    output logic        bus_write,
    output logic [7:0]  bus_addr,
    output logic [15:0] bus_wdata,
    input  logic [15:0] bus_rdata
);
    logic          req_tgl, req_s, ack_tgl, ack_s;
    xfer_t         xfer;
    ctl_t          ctl;
    logic [HB-1:0] addr;
    logic [DW-1:0] core_rdata;

    hcp_host_regs #(.LOCAL_REGS(LOCAL_REGS)) u_host (
        .clk(hclk), .rst(hrst), .sel(h_sel), .wr_en(h_wr_en), .wdata(h_wdata),
        .rdata(h_rdata), .ack_s(ack_s), .core_rdata(core_rdata),
        .req_tgl(req_tgl), .xfer(xfer), .ctl(ctl), .addr(addr)
    );

    hcp_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(cclk), .rst(crst), .d(req_tgl), .q(req_s)
    );

    hcp_core_master u_core (
        .clk(cclk), .rst(crst), .req_s(req_s), .xfer(xfer),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_tgl(ack_tgl), .rdata_q(core_rdata)
    );

    hcp_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(hclk), .rst(hrst), .d(ack_tgl), .q(ack_s)
    );
endmodule

// File: rtl/hcp_checker.sv
module hcp_checker #(
    parameter int LOCAL_REGS = 4
) (
    input logic       hclk,
    input logic       hrst,
    input logic       cclk,
    input logic       crst,
    input logic [1:0] sel,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       busy,
    input logic       rd,
    input logic       wr,
    input logic       term,
    input logic [7:0] addr,
    input logic       bus_valid
);
    assert_reserved_zero_R2: assert property (@(posedge hclk) disable iff (hrst)
        (sel == 2'b00) |-> (rdata[7:4] == 4'b0000));

    // R3 and R6: a pending command carries exactly one of read or write
    assert_busy_one_cmd_R3: assert property (@(posedge hclk) disable iff (hrst)
        busy |-> (rd ^ wr));

    assert_local_no_busy_R5: assert property (@(posedge hclk) disable iff (hrst)
        (wr_en && sel == 2'b00 && (wdata[1] || wdata[2]) && !busy && !term
         && ({24'd0, addr} < LOCAL_REGS)) |=> !busy);

    assert_addr_locked_R7: assert property (@(posedge hclk) disable iff (hrst)
        busy |=> (!busy || $stable(addr)));

    assert_term_idle_R8: assert property (@(posedge hclk) disable iff (hrst)
        term |-> !busy);

    assert_soft_reset_R9: assert property (@(posedge hclk) disable iff (hrst)
        (wr_en && sel == 2'b00 && wdata[7]) |=> (!busy && !term && addr == 8'h00));

    assert_single_strobe_R10: assert property (@(posedge cclk) disable iff (crst)
        bus_valid |=> !bus_valid);
endmodule

bind host_cmd_port hcp_checker #(.LOCAL_REGS(LOCAL_REGS)) u_chk (
    .hclk(hclk), .hrst(hrst), .cclk(cclk), .crst(crst),
    .sel(h_sel), .wr_en(h_wr_en), .wdata(h_wdata), .rdata(h_rdata),
    .busy(ctl.busy), .rd(ctl.rd), .wr(ctl.wr), .term(ctl.term),
    .addr(addr), .bus_valid(bus_valid)
);

// File: tb/sim_host_cmd_port.sv
`timescale 1ns/1ps
module sim_host_cmd_port;
    logic        hclk = 1'b0, cclk = 1'b0, cclk_en = 1'b1;
    logic        hrst = 1'b1, crst = 1'b1;
    logic [1:0]  h_sel = 2'b00;
    logic        h_wr_en = 1'b0;
    logic [7:0]  h_wdata = 8'h00;
    logic [7:0]  h_rdata;
    logic        bus_valid, bus_write;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;

    logic [15:0] mem [256];
    int checks = 0, failures = 0, nbus = 0;
    bit done_flag = 1'b0;

    always #10 hclk = ~hclk;
    always #7  if (cclk_en) cclk = ~cclk;

    host_cmd_port #(.LOCAL_REGS(4), .SYNC_STAGES(3)) u0 (
        .hclk(hclk), .hrst(hrst), .h_sel(h_sel), .h_wr_en(h_wr_en),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .cclk(cclk), .crst(crst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    assign bus_rdata = mem[bus_addr];
    always @(posedge cclk) begin
        if (!crst && bus_valid) begin
            nbus++;
            if (bus_write) mem[bus_addr] <= bus_wdata;
        end
    end

    // bit 24: 1 = read; 23:16 address; 15:0 data written or expected
    localparam logic [24:0] VEC [9] = '{
        {1'b0, 8'h20, 16'hA5C3}, {1'b0, 8'h7F, 16'h1234}, {1'b0, 8'h02, 16'hBEEF},
        {1'b1, 8'h20, 16'hA5C3}, {1'b1, 8'h7F, 16'h1234}, {1'b1, 8'h02, 16'hBEEF},
        {1'b0, 8'h20, 16'h0F0F}, {1'b1, 8'h20, 16'h0F0F}, {1'b1, 8'h03, 16'h0000}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] s, input logic [7:0] d);
        @(negedge hclk);
        h_sel = s; h_wdata = d; h_wr_en = 1'b1;
        @(negedge hclk);
        h_wr_en = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] s, output logic [7:0] d);
        h_sel = s;
        #1 d = h_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] st;
        for (int i = 0; i < 200; i++) begin
            hrd(2'b00, st);
            if (!st[0]) return;
            @(negedge hclk);
        end
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        hrd(2'b10, lo); hrd(2'b11, hi);
        v = {hi, lo};
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #3000000;
        if (!done_flag) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] b;
        logic [15:0] w;
        int n0;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
        repeat (4) @(negedge hclk);
        hrst = 1'b0; crst = 1'b0;
        @(negedge hclk);

        // R1 reset state of all four host registers
        for (int s = 0; s < 4; s++) begin
            hrd(2'(s), b);
            chk(b == 8'h00, "R1 reset value", b, 0);
        end

        // vector table: R3, R4, R5, R10
        foreach (VEC[k]) begin
            hwr(2'b01, VEC[k][23:16]);
            if (!VEC[k][24]) begin
                hwr(2'b10, VEC[k][7:0]);
                hwr(2'b11, VEC[k][15:8]);
                n0 = nbus;
                hwr(2'b00, 8'h04);
                hrd(2'b00, b);
                if (VEC[k][23:16] < 8'd4) chk(b == 8'h00, "R5 local write no busy", b, 8'h00);
                else                      chk(b == 8'h05, "R3 busy during write", b, 8'h05);
                wait_idle();
                repeat (2) @(negedge hclk);
                hrd(2'b00, b);
                chk(b == 8'h00, "R3 write bit self-clears", b, 0);
                if (VEC[k][23:16] >= 8'd4) begin
                    chk(mem[VEC[k][23:16]] == VEC[k][15:0], "R3 core register written",
                        mem[VEC[k][23:16]], VEC[k][15:0]);
                    chk(nbus - n0 == 1, "R10 one strobe per command", nbus - n0, 1);
                end
            end else begin
                hwr(2'b00, 8'h02);
                hrd(2'b00, b);
                if (VEC[k][23:16] < 8'd4) chk(b == 8'h00, "R5 local read no busy", b, 8'h00);
                else                      chk(b == 8'h03, "R4 busy during read", b, 8'h03);
                wait_idle();
                rd16(w);
                chk(w == VEC[k][15:0], "R4 read data", w, VEC[k][15:0]);
            end
        end

        // R7: address and data writes ignored while busy
        hwr(2'b01, 8'h30); hwr(2'b10, 8'h11); hwr(2'b11, 8'h11);
        hwr(2'b00, 8'h04);
        hwr(2'b10, 8'h99);
        hwr(2'b01, 8'h31);
        wait_idle();
        hrd(2'b10, b); chk(b == 8'h11, "R7 data held while busy", b, 8'h11);
        hrd(2'b01, b); chk(b == 8'h30, "R7 address held while busy", b, 8'h30);
        chk(mem[8'h31] == 16'h0000, "R7 no write to late address", mem[8'h31], 0);

        // R6: read wins over write
        hwr(2'b10, 8'h22); hwr(2'b11, 8'h22);
        hwr(2'b00, 8'h06);
        hrd(2'b00, b); chk(b == 8'h03, "R6 only read pending", b, 8'h03);
        wait_idle();
        rd16(w);
        chk(w == 16'h1111, "R6 read result", w, 16'h1111);
        chk(mem[8'h30] == 16'h1111, "R6 write dropped", mem[8'h30], 16'h1111);

        // R8: abort with the core clock stopped
        cclk_en = 1'b0;
        hwr(2'b01, 8'h40); hwr(2'b10, 8'h55); hwr(2'b11, 8'h55);
        hwr(2'b00, 8'h04);
        repeat (20) @(negedge hclk);
        hrd(2'b00, b); chk(b == 8'h05, "R8 hung while core stopped", b, 8'h05);
        hwr(2'b00, 8'h08);
        hrd(2'b00, b); chk(b == 8'h08, "R8 abort clears busy", b, 8'h08);
        hwr(2'b00, 8'h0C);
        hrd(2'b00, b); chk(b == 8'h08, "R8 command ignored under abort", b, 8'h08);
        hwr(2'b00, 8'h00);
        hrd(2'b00, b); chk(b == 8'h00, "R8 abort cleared by host", b, 0);
        cclk_en = 1'b1;
        repeat (30) @(negedge hclk);
        chk(mem[8'h40] == 16'h0000, "R8 aborted write not applied", mem[8'h40], 0);
        hwr(2'b01, 8'h41); hwr(2'b10, 8'h77); hwr(2'b11, 8'h77);
        hwr(2'b00, 8'h04);
        wait_idle();
        chk(mem[8'h41] == 16'h7777, "R8 normal operation resumes", mem[8'h41], 16'h7777);

        // R2: reserved bits
        hwr(2'b00, 8'h70);
        hrd(2'b00, b); chk(b == 8'h00, "R2 reserved bits read zero", b, 0);

        // R9: soft reset
        hwr(2'b01, 8'h55); hwr(2'b10, 8'hCD); hwr(2'b11, 8'hAB);
        hwr(2'b00, 8'h80);
        for (int s = 0; s < 4; s++) begin
            hrd(2'(s), b);
            chk(b == 8'h00, "R9 register cleared", b, 0);
        end
        hwr(2'b01, 8'h02); hwr(2'b00, 8'h02);
        rd16(w); chk(w == 16'h0000, "R9 local register cleared", w, 0);

        done_flag = 1'b1;
        finish_run();
    end
endmodule